// File: doc/BRIEF.md
# Programmable Field Vertical Sync Generator

This block produces the vertical sync pulse of an interlaced 525-line video stream, together with a V flag that is meant for insertion into an embedded timing reference code. It does not count lines or pixels itself. It watches an external line counter, a horizontal position counter, an odd/even field indicator and a pixel-clock strobe. It raises the pulse and drops it at positions that a small control register set places.

Each edge of the pulse is placed relative to a fixed reference line for each field. The start edge and the stop edge each carry a sign-magnitude offset measured in lines. Each edge also has one control bit per field that adds one extra line of delay, and one bit per field that pulls the edge back by half a line. Register writes are collected in a pending copy. The pending copy moves into the active copy only when the field indicator changes, so a pulse that is in progress always finishes with the settings it started with.

A two-state machine drives the output. Its states are `ST_LOW` (pulse inactive) and `ST_HIGH` (pulse active). The transition `ST_LOW -> ST_HIGH` fires on a strobe at the computed start point, provided that the computed stop point is not the same point. The transition `ST_HIGH -> ST_LOW` fires on a strobe at the computed stop point. In every other cycle the machine stays in its current state.

Top module: `vsync_timing_gen`

## Requirements
- R1: After reset, `vsync` and `v_flag` are 0. The register defaults are: start edge advanced by 5 lines (address 0 = 0x85), stop edge delayed by 0 lines (address 1 = 0x00), and all per-field adjustment bits clear (address 2 = 0x00).
- R2: `vsync` goes from 0 to 1 on the clock edge that samples `pix_stb`=1 while `line_cnt` and `h_cnt` equal the computed start point.
- R3: `vsync` goes from 1 to 0 on the clock edge that samples `pix_stb`=1 while `line_cnt` and `h_cnt` equal the computed stop point.
- R4: Addresses 0 (start edge) and 1 (stop edge) each hold a 5-bit line magnitude in bits [4:0] and a direction bit in bit 7. Bit 7 = 1 places the edge magnitude lines before the field's reference line. Bit 7 = 0 places it magnitude lines after. The reference line is REF_ODD in the odd field (`field_odd`=1) and REF_EVEN in the even field. Line arithmetic wraps modulo LINES.
- R5: Address 2 bits [3:0] add one line of delay. Bit 0 applies to the start edge in the odd field, bit 1 to the start edge in the even field, bit 2 to the stop edge in the odd field, and bit 3 to the stop edge in the even field.
- R6: Address 2 bits [7:4] apply a half-line advance, in the same order as R5: bit 4 start/odd, bit 5 start/even, bit 6 stop/odd, bit 7 stop/even. With the bit set, the edge sits on the line before its computed line, at `h_cnt` = H_TOTAL/2. Without it, the edge sits at `h_cnt` = 0.
- R7: A clock in which `pix_stb` is 0 leaves `vsync` unchanged, even when the counters sit on an edge point.
- R8: `v_flag` equals `vsync` in every cycle.
- R9: A write (`cfg_we`=1) affects the edges only from the first strobe at which `field_odd` differs from its value at the previous strobe. The positions used up to and including that strobe come from the earlier settings.
- R10: When the computed start and stop points of a field coincide, `vsync` stays 0 for that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_stb | input | 1 | Pixel strobe; counters are valid and edges may fire |
| line_cnt | input | LW | Current line, 0 to LINES-1 |
| h_cnt | input | HW | Current horizontal position, 0 to H_TOTAL-1 |
| field_odd | input | 1 | 1 in the odd field, 0 in the even field |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address (0 start, 1 stop, 2 field adjust, 3 unused) |
| cfg_wdata | input | 8 | Register write data |
| vsync | output | 1 | Vertical sync pulse |
| v_flag | output | 1 | V flag for the embedded timing code, equal to `vsync` |

## Verification
Two functions can act on the same clock. The first is the field-boundary transfer of pending settings into the active copy. The second is edge detection, either at the same strobe or while the pulse is still high. The bench provokes this by writing new edge positions while the pulse is active, partway through a field. The scoreboard then expects the pulse to end at the old stop line, and expects the new settings to apply only from the next field onwards. A second meeting point is the start and stop compare firing at the same strobe. Here the bench programs coincident edges for a whole field and expects no pulse at all.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef struct packed {
        logic       adv;
        logic [4:0] mag;
    } vsg_offs_t;

    typedef struct packed {
        vsg_offs_t  beg;
        vsg_offs_t  fin;
        logic [3:0] dly;
        logic [3:0] half;
    } vsg_cfg_t;

    localparam vsg_cfg_t VSG_CFG_RST = '{
        beg:  '{adv: 1'b1, mag: 5'd5},
        fin:  '{adv: 1'b0, mag: 5'd0},
        dly:  4'h0,
        half: 4'h0
    };

    typedef enum logic [0:0] {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } vsg_state_t;

    localparam int VSG_EDGES = 2;

endpackage

// File: rtl/vsg_cfg_regs.sv
module vsg_cfg_regs
    import vsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pix_stb,
    input  logic       field_odd,
    input  logic       cfg_we,
    input  logic [1:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output vsg_cfg_t   act_cfg
);

    vsg_cfg_t pend_cfg;
    logic     prev_field;
    logic     field_start;

    assign field_start = pix_stb && (field_odd != prev_field);

    // Pending copy: written by the host port at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cfg <= VSG_CFG_RST;
        end else if (cfg_we) begin
            case (cfg_addr)
                2'd0: begin
                    pend_cfg.beg.adv <= cfg_wdata[7];
                    pend_cfg.beg.mag <= cfg_wdata[4:0];
                end
                2'd1: begin
                    pend_cfg.fin.adv <= cfg_wdata[7];
                    pend_cfg.fin.mag <= cfg_wdata[4:0];
                end
                2'd2: begin
                    pend_cfg.dly  <= cfg_wdata[3:0];
                    pend_cfg.half <= cfg_wdata[7:4];
                end
                default: ;
            endcase
        end
    end

    // Active copy: moves only on a field change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg    <= VSG_CFG_RST;
            prev_field <= 1'b1;
        end else begin
            if (field_start) begin
                act_cfg <= pend_cfg;
            end
            if (pix_stb) begin
                prev_field <= field_odd;
            end
        end
    end

    // R9: active settings never move in the middle of a field
    a_r9_hold_mid_field: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> $stable(act_cfg))
        else $error("a_r9_hold_mid_field");

endmodule

// File: rtl/vsg_edge_point.sv
module vsg_edge_point
    import vsg_pkg::*;
#(
    parameter int LINES    = 525,
    parameter int H_TOTAL  = 858,
    parameter int REF_ODD  = 10,
    parameter int REF_EVEN = 273,
    parameter int LW       = 10,
    parameter int HW       = 10
)(
    input  vsg_offs_t         offs,
    input  logic              dly_odd,
    input  logic              dly_even,
    input  logic              half_odd,
    input  logic              half_even,
    input  logic              field_odd,
    input  logic [LW-1:0]     line_cnt,
    input  logic [HW-1:0]     h_cnt,
    output logic              hit
);

    localparam int SW = LW + 2;
    localparam logic [SW-1:0] L1   = SW'(LINES);
    localparam logic [SW-1:0] L2   = SW'(2 * LINES);
    localparam logic [HW-1:0] HMID = HW'(H_TOTAL / 2);

    logic [SW-1:0] base;
    logic [SW-1:0] sum;
    logic [SW-1:0] mag_w;
    logic          dly_sel;
    logic          half_sel;
    logic [LW-1:0] tgt_line;
    logic [HW-1:0] tgt_h;

    always_comb begin
        base     = field_odd ? SW'(REF_ODD) : SW'(REF_EVEN);
        dly_sel  = field_odd ? dly_odd  : dly_even;
        half_sel = field_odd ? half_odd : half_even;
        mag_w    = {{(SW-5){1'b0}}, offs.mag};
        // bias by one frame so the subtraction never goes negative
        sum = base + L1 + {{(SW-1){1'b0}}, dly_sel};
        if (offs.adv) begin
            sum = sum - mag_w;
        end else begin
            sum = sum + mag_w;
        end
        if (half_sel) begin
            sum = sum - {{(SW-1){1'b0}}, 1'b1};
        end
        if (sum >= L2) begin
            sum = sum - L2;
        end else if (sum >= L1) begin
            sum = sum - L1;
        end
        tgt_line = sum[LW-1:0];
        tgt_h    = half_sel ? HMID : '0;
        hit      = (line_cnt == tgt_line) && (h_cnt == tgt_h);
    end

endmodule

// File: rtl/vsg_sync_fsm.sv
module vsg_sync_fsm
    import vsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pix_stb,
    input  logic beg_hit,
    input  logic end_hit,
    output logic vsync,
    output logic v_flag
);

    vsg_state_t state_q;
    vsg_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (pix_stb && beg_hit && !end_hit) state_d = ST_HIGH;
            ST_HIGH: if (pix_stb && end_hit)             state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync  <= 1'b0;
            v_flag <= 1'b0;
        end else begin
            vsync  <= (state_d == ST_HIGH);
            v_flag <= (state_d == ST_HIGH);
        end
    end

    a_r8_flag_tracks_pin: assert property (@(posedge clk) disable iff (!rst_n)
        v_flag == vsync)
        else $error("a_r8_flag_tracks_pin");

    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_stb |=> $stable(vsync))
        else $error("a_r7_hold_without_strobe");

    a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> $past(pix_stb && beg_hit))
        else $error("a_r2_rise_at_start");

    a_r3_fall_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync) |-> $past(pix_stb && end_hit))
        else $error("a_r3_fall_at_stop");

    a_r10_coincident_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && beg_hit && end_hit && !vsync) |=> !vsync)
        else $error("a_r10_coincident_stays_low");

endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
    import vsg_pkg::*;
#(
    parameter int LINES    = 525,
    parameter int H_TOTAL  = 858,
    parameter int REF_ODD  = 10,
    parameter int REF_EVEN = 273,
    parameter int LW       = $clog2(LINES),
    parameter int HW       = $clog2(H_TOTAL)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_stb,
    input  logic [LW-1:0] line_cnt,
    input  logic [HW-1:0] h_cnt,
    input  logic          field_odd,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    output logic          vsync,
    output logic          v_flag
);

    vsg_cfg_t               act_cfg;
    logic [VSG_EDGES-1:0]   hit;

    vsg_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_stb   (pix_stb),
        .field_odd (field_odd),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .act_cfg   (act_cfg)
    );

    // edge 0 = start, edge 1 = stop; adjust bits indexed 2*edge + (even field)
    for (genvar g = 0; g < VSG_EDGES; g++) begin : g_edge
        vsg_edge_point #(
            .LINES    (LINES),
            .H_TOTAL  (H_TOTAL),
            .REF_ODD  (REF_ODD),
            .REF_EVEN (REF_EVEN),
            .LW       (LW),
            .HW       (HW)
        ) u_pt (
            .offs      ((g == 0) ? act_cfg.beg : act_cfg.fin),
            .dly_odd   (act_cfg.dly[2*g]),
            .dly_even  (act_cfg.dly[2*g+1]),
            .half_odd  (act_cfg.half[2*g]),
            .half_even (act_cfg.half[2*g+1]),
            .field_odd (field_odd),
            .line_cnt  (line_cnt),
            .h_cnt     (h_cnt),
            .hit       (hit[g])
        );
    end

    vsg_sync_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_stb (pix_stb),
        .beg_hit (hit[0]),
        .end_hit (hit[1]),
        .vsync   (vsync),
        .v_flag  (v_flag)
    );

endmodule

// File: tb/tb_vsync_timing_gen.sv
module tb_vsync_timing_gen;

    localparam int LINES = 525;
    localparam int HT    = 16;
    localparam int RODD  = 10;
    localparam int REVEN = 273;
    localparam int LW    = 10;
    localparam int HW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_stb = 1'b0;
    logic [LW-1:0] line_cnt = '0;
    logic [HW-1:0] h_cnt = '0;
    logic          field_odd = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          vsync, v_flag;

    always #10 clk = ~clk;

    vsync_timing_gen #(
        .LINES(LINES), .H_TOTAL(HT), .REF_ODD(RODD), .REF_EVEN(REVEN), .LW(LW), .HW(HW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_cnt(line_cnt), .h_cnt(h_cnt),
        .field_odd(field_odd), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .vsync(vsync), .v_flag(v_flag)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    logic [7:0] m_pend [3];
    logic [7:0] m_act  [3];
    logic       m_prev;
    logic       m_state;

    function automatic void edge_pt(input logic [7:0] ob, input logic dly, input logic hf,
                                    input logic odd, output int ln, output int hp);
        int v;
        v = odd ? RODD : REVEN;
        v = ob[7] ? v - int'(ob[4:0]) : v + int'(ob[4:0]);
        v = v + int'(dly) - int'(hf);
        ln = ((v % LINES) + LINES) % LINES;
        hp = hf ? HT / 2 : 0;
    endfunction

    task automatic step(input logic stb, input int ln, input int h, input logic odd,
                        input logic we, input logic [1:0] a, input logic [7:0] d, input string tag);
        int  bl, bh, el, eh, k;
        bit  bhit, ehit;
        item_t it;
        @(negedge clk);
        pix_stb = stb; line_cnt = LW'(ln); h_cnt = HW'(h); field_odd = odd;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        k = odd ? 0 : 1;
        if (stb) begin
            edge_pt(m_act[0], m_act[2][k],   m_act[2][4+k], odd, bl, bh);
            edge_pt(m_act[1], m_act[2][2+k], m_act[2][6+k], odd, el, eh);
            bhit = (ln == bl) && (h == bh);
            ehit = (ln == el) && (h == eh);
            if (!m_state && bhit && !ehit) m_state = 1'b1;
            else if (m_state && ehit)      m_state = 1'b0;
            if (odd != m_prev) begin
                for (int i = 0; i < 3; i++) m_act[i] = m_pend[i];
            end
            m_prev = odd;
        end
        if (we && a != 2'd3) m_pend[a] = d;
        it.exp = m_state;
        it.tag = stb ? tag : "R7 no strobe";
        q.push_back(it);
    endtask

    task automatic run_frame(input string tag, input int wl,
                             input logic [7:0] w0, input logic [7:0] w1, input logic [7:0] w2);
        for (int ln = 0; ln < LINES; ln++) begin
            for (int h = 0; h < HT; h++) begin
                logic odd;
                odd = (ln < 263);
                if (h % 4 == 0) step(1'b0, ln, h, odd, 1'b0, 2'd0, 8'h00, tag);
                step(1'b1, ln, h, odd, 1'b0, 2'd0, 8'h00, tag);
                if (ln == wl && h == 0) begin
                    step(1'b0, ln, h, odd, 1'b1, 2'd0, w0, tag);
                    step(1'b0, ln, h, odd, 1'b1, 2'd1, w1, tag);
                    step(1'b0, ln, h, odd, 1'b1, 2'd2, w2, tag);
                    step(1'b0, ln, h, odd, 1'b1, 2'd3, 8'hFF, tag);
                end
            end
        end
    endtask

    // monitor: compares one scoreboard item per clock
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (vsync !== it.exp) begin
                n_fail++;
                $display("FAIL %s: vsync=%0b expected %0b at line %0d h %0d",
                         it.tag, vsync, it.exp, line_cnt, h_cnt);
            end
            n_chk++;
            if (v_flag !== vsync) begin
                n_fail++;
                $display("FAIL R8: v_flag=%0b expected %0b", v_flag, vsync);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_pend[0] = 8'h85; m_pend[1] = 8'h00; m_pend[2] = 8'h00;
        for (int i = 0; i < 3; i++) m_act[i] = m_pend[i];
        m_prev = 1'b1;
        m_state = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        n_chk++;
        if (vsync !== 1'b0 || v_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: vsync=%0b v_flag=%0b expected 0 0 in reset", vsync, v_flag);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // defaults, then a mid-pulse rewrite (odd line 7) effective from the even field
        run_frame("R1 R2 R3 R4 R9", 7, 8'h02, 8'h06, 8'h81);
        // start/stop delayed, odd one-line delay, even stop half advance
        run_frame("R4 R5 R6 R9", 300, 8'h83, 8'h83, 8'h00);
        // coincident edges in odd field; new half-advance set lands in even field
        run_frame("R10 R6 R9", 200, 8'h85, 8'h00, 8'h34);
        run_frame("R5 R6 R2 R3", -1, 8'h00, 8'h00, 8'h00);
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule